// File: doc/BRIEF.md
# Palette VGA Pixel Output Stage

This stage is the last step before a video DAC. Each pixel clock it takes a pixel word fetched from video memory, plus the sync pulses, blanking flag and beam position from a raster timing generator. It produces a 24-bit colour and the sync outputs that go to the converter. A two-bit mode input, sampled with each pixel, picks how the pixel word becomes a colour:

- **Indexed:** the low eight bits address a writable 256-entry table of 24-bit colours.
- **Direct:** the whole 24-bit word is used as the colour.
- **Eight-colour:** three bits each switch one channel fully on.

The table is read synchronously, which costs one cycle. Every other path (syncs, blanking, beam position and the direct and eight-colour paths) is delayed by that same one cycle, so every output field belongs to the same pixel. While blanking is active the colour is black. A separate host port loads table entries, one per clock.

Top module: `vga_pixel_out`

## Requirements
- R1: While `rst` is high, `rgb_o` is zero and both `hsync_n_o` and `vsync_n_o` are high, whatever the inputs are.
- R2: With `mode_i` = 2'b00 (indexed), the `rgb_o` one cycle after a pixel is presented equals the table entry addressed by `pix_i[7:0]`, packed red in [23:16], green in [15:8], blue in [7:0].
- R3: A table write (`pal_we_i` high) is seen by a pixel presented on the next cycle or later. A pixel presented in the same cycle as a write to its own index receives the old entry.
- R4: With `mode_i` = 2'b01 or 2'b11 (direct), `rgb_o` one cycle later equals `pix_i`.
- R5: With `mode_i` = 2'b10 (eight-colour), `pix_i[2]` sets red to 8'hFF, `pix_i[1]` sets green to 8'hFF and `pix_i[0]` sets blue to 8'hFF. A cleared bit gives a channel of zero, and `pix_i[23:3]` has no effect.
- R6: When `blank_i` was high one cycle earlier, `rgb_o` is zero in every mode.
- R7: `hsync_n_o` and `vsync_n_o` equal `hsync_n_i` and `vsync_n_i` from one cycle earlier, with the active-low polarity kept.
- R8: `hpos_o` and `vpos_o` equal `hpos_i` and `vpos_i` from one cycle earlier.
- R9: The mode is sampled with each pixel, so changing `mode_i` between consecutive pixels changes only the pixels presented after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_i | input | 24 | Pixel word from video memory |
| mode_i | input | 2 | Colour mode: 00 indexed, 01/11 direct, 10 eight-colour |
| hpos_i | input | 11 | Horizontal beam position |
| vpos_i | input | 10 | Vertical beam position |
| blank_i | input | 1 | Blanking flag, active high |
| hsync_n_i | input | 1 | Horizontal sync, active low |
| vsync_n_i | input | 1 | Vertical sync, active low |
| pal_we_i | input | 1 | Table write enable |
| pal_addr_i | input | 8 | Table write index |
| pal_data_i | input | 24 | Table write colour |
| rgb_o | output | 24 | Colour to DAC, red in [23:16] |
| hsync_n_o | output | 1 | Aligned horizontal sync, active low |
| vsync_n_o | output | 1 | Aligned vertical sync, active low |
| hpos_o | output | 11 | Aligned horizontal position |
| vpos_o | output | 10 | Aligned vertical position |

## Verification
On every cycle, the assertions check four things:

- blanking forces black one cycle later;
- the syncs and positions trail their inputs by exactly one cycle;
- direct pixels emerge unchanged;
- eight-colour pixels expand to full-scale channels.

Only the bench scenarios can show the table contents themselves. These are the indexed lookup after a full load, the next-cycle visibility of a write, the old-value result of a same-cycle write and read, and per-pixel mode switching. The bench checks these against its own model of the table.

// File: rtl/vga_pal_pkg.sv
package vga_pal_pkg;

    localparam int CH_W  = 8;
    localparam int IDX_W = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef enum logic [1:0] {
        MODE_INDEXED = 2'b00,
        MODE_DIRECT  = 2'b01,
        MODE_EIGHT   = 2'b10,
        MODE_DIRECT2 = 2'b11
    } color_mode_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    function automatic rgb_t eight_color(input logic [2:0] bits);
        rgb_t c;
        c.r = {CH_W{bits[2]}};
        c.g = {CH_W{bits[1]}};
        c.b = {CH_W{bits[0]}};
        return c;
    endfunction

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read-first: a same-cycle write is not seen by this read
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/timing_delay.sv
module timing_delay #(
    parameter int XW = 11,
    parameter int YW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hs_n_i,
    input  logic          vs_n_i,
    input  logic          blank_i,
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    output logic          hs_n_o,
    output logic          vs_n_o,
    output logic          blank_o,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_n_o  <= 1'b1;
            vs_n_o  <= 1'b1;
            blank_o <= 1'b1;
            x_o     <= '0;
            y_o     <= '0;
        end else begin
            hs_n_o  <= hs_n_i;
            vs_n_o  <= vs_n_i;
            blank_o <= blank_i;
            x_o     <= x_i;
            y_o     <= y_i;
        end
    end
endmodule

// File: rtl/color_select.sv
module color_select
    import vga_pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [RGB_W-1:0] pix_i,
    input  logic [RGB_W-1:0] pal_q,
    input  logic             blank_q,
    output logic [RGB_W-1:0] rgb_o
);
    color_mode_e      mode_q;
    logic [RGB_W-1:0] pix_q;
    rgb_t             chosen;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_DIRECT;
            pix_q  <= '0;
        end else begin
            mode_q <= color_mode_e'(mode_i);
            pix_q  <= pix_i;
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_INDEXED: chosen = rgb_t'(pal_q);
            MODE_EIGHT:   chosen = eight_color(pix_q[2:0]);
            default:      chosen = rgb_t'(pix_q);
        endcase
    end

    assign rgb_o = blank_q ? '0 : RGB_W'(chosen);
endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out
    import vga_pal_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RGB_W-1:0] pix_i,
    input  logic [1:0]       mode_i,
    input  logic [XW-1:0]    hpos_i,
    input  logic [YW-1:0]    vpos_i,
    input  logic             blank_i,
    input  logic             hsync_n_i,
    input  logic             vsync_n_i,
    input  logic             pal_we_i,
    input  logic [IDX_W-1:0] pal_addr_i,
    input  logic [RGB_W-1:0] pal_data_i,
    output logic [RGB_W-1:0] rgb_o,
    output logic             hsync_n_o,
    output logic             vsync_n_o,
    output logic [XW-1:0]    hpos_o,
    output logic [YW-1:0]    vpos_o
);
    logic [RGB_W-1:0] pal_q;
    logic             blank_q;

    pal_ram #(.AW(IDX_W), .DW(RGB_W)) u_ram (
        .clk   (clk),
        .we    (pal_we_i),
        .waddr (pal_addr_i),
        .wdata (pal_data_i),
        .raddr (pix_i[IDX_W-1:0]),
        .rdata (pal_q)
    );

    timing_delay #(.XW(XW), .YW(YW)) u_tim (
        .clk     (clk),
        .rst     (rst),
        .hs_n_i  (hsync_n_i),
        .vs_n_i  (vsync_n_i),
        .blank_i (blank_i),
        .x_i     (hpos_i),
        .y_i     (vpos_i),
        .hs_n_o  (hsync_n_o),
        .vs_n_o  (vsync_n_o),
        .blank_o (blank_q),
        .x_o     (hpos_o),
        .y_o     (vpos_o)
    );

    color_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .pix_i   (pix_i),
        .pal_q   (pal_q),
        .blank_q (blank_q),
        .rgb_o   (rgb_o)
    );

    // one-cycle-after-reset marker for the checks below
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    p_blank_black_r6: assert property (@(posedge clk) disable iff (rst)
        $past(blank_i) |-> rgb_o == '0);

    p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (hsync_n_o == $past(hsync_n_i)) && (vsync_n_o == $past(vsync_n_i)));

    p_pos_delay_r8: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (hpos_o == $past(hpos_i)) && (vpos_o == $past(vpos_i)));

    p_direct_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(blank_i) && $past(mode_i[0])) |-> rgb_o == $past(pix_i));

    p_eight_color_r5: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(blank_i) && $past(mode_i) == 2'b10)
        |-> rgb_o == {{CH_W{$past(pix_i[2])}}, {CH_W{$past(pix_i[1])}}, {CH_W{$past(pix_i[0])}}});

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (hsync_n_o && vsync_n_o && rgb_o == '0));
endmodule

// File: tb/vga_pixel_out_test.sv
module vga_pixel_out_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pix_i = '0;
    logic [1:0]  mode_i = '0;
    logic [10:0] hpos_i = '0;
    logic [9:0]  vpos_i = '0;
    logic        blank_i = 1'b0;
    logic        hsync_n_i = 1'b1;
    logic        vsync_n_i = 1'b1;
    logic        pal_we_i = 1'b0;
    logic [7:0]  pal_addr_i = '0;
    logic [23:0] pal_data_i = '0;
    logic [23:0] rgb_o;
    logic        hsync_n_o, vsync_n_o;
    logic [10:0] hpos_o;
    logic [9:0]  vpos_o;

    vga_pixel_out uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [23:0] rgb;
        logic        hs, vs;
        logic [10:0] x;
        logic [9:0]  y;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [23:0] model [256];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    function automatic logic [23:0] expand8(input logic [2:0] b);
        return {{8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    endfunction

    task automatic drive(input logic [23:0] p, input logic [1:0] m, input logic bl,
                         input logic hs, input logic vs, input logic [10:0] x,
                         input logic [9:0] y, input logic we, input logic [7:0] wa,
                         input logic [23:0] wd, input string tag);
        item_t e;
        @(negedge clk);
        pix_i = p; mode_i = m; blank_i = bl; hsync_n_i = hs; vsync_n_i = vs;
        hpos_i = x; vpos_i = y; pal_we_i = we; pal_addr_i = wa; pal_data_i = wd;
        if (bl)              e.rgb = '0;
        else if (m == 2'b00) e.rgb = model[p[7:0]];
        else if (m == 2'b10) e.rgb = expand8(p[2:0]);
        else                 e.rgb = p;
        e.hs = hs; e.vs = vs; e.x = x; e.y = y; e.tag = tag;
        sb.push_back(e);
        if (we) model[wa] = wd;
    endtask

    task automatic px(input logic [23:0] p, input logic [1:0] m, input string tag);
        drive(p, m, 1'b0, 1'b1, 1'b1, 11'd5, 10'd7, 1'b0, 8'd0, 24'd0, tag);
    endtask

    // monitor: compares each result one step after the capturing edge
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            checks++;
            if (rgb_o !== e.rgb || hsync_n_o !== e.hs || vsync_n_o !== e.vs ||
                hpos_o !== e.x || vpos_o !== e.y) begin
                errors++;
                $display("FAIL %s: rgb=%h hs=%b vs=%b x=%0d y=%0d expected rgb=%h hs=%b vs=%b x=%0d y=%0d",
                         e.tag, rgb_o, hsync_n_o, vsync_n_o, hpos_o, vpos_o,
                         e.rgb, e.hs, e.vs, e.x, e.y);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle during reset despite active inputs
        pix_i = 24'hABCDEF; hsync_n_i = 1'b0; vsync_n_i = 1'b0; blank_i = 1'b0; mode_i = 2'b01;
        repeat (3) @(negedge clk);
        checks++;
        if (rgb_o !== 24'h0 || hsync_n_o !== 1'b1 || vsync_n_o !== 1'b1) begin
            errors++;
            $display("FAIL R1: rgb=%h hs=%b vs=%b expected rgb=000000 hs=1 vs=1",
                     rgb_o, hsync_n_o, vsync_n_o);
        end
        rst = 1'b0;

        // load the whole table while blanked (R6 blanking over every index)
        for (int i = 0; i < 256; i++)
            drive(24'(i), 2'b00, 1'b1, 1'b1, 1'b0, 11'(i), 10'd500, 1'b1, 8'(i),
                  {8'(i), 8'(255 - i), 8'(i ^ 8'h5A)}, "R6");

        // R2: indexed lookups, upper pixel bits must not matter
        px(24'h000000, 2'b00, "R2");
        px(24'h0000FF, 2'b00, "R2");
        px(24'hFFFF80, 2'b00, "R2");
        for (int i = 0; i < 16; i++) px(24'(i * 17), 2'b00, "R2");

        // R3: write then read on the next cycle sees new value
        drive(24'h000010, 2'b00, 1'b0, 1'b1, 1'b1, 11'd1, 10'd1, 1'b1, 8'h20, 24'h123456, "R3");
        px(24'h000020, 2'b00, "R3");
        // R3: same-cycle write and read of one index yields old value
        drive(24'h000030, 2'b00, 1'b0, 1'b1, 1'b1, 11'd2, 10'd1, 1'b0, 8'h00, 24'h0, "R3");
        begin
            item_t e;
            @(negedge clk);
            pix_i = 24'h000030; mode_i = 2'b00; blank_i = 1'b0; hsync_n_i = 1'b1; vsync_n_i = 1'b1;
            hpos_i = 11'd3; vpos_i = 10'd1; pal_we_i = 1'b1; pal_addr_i = 8'h30; pal_data_i = 24'hFEDCBA;
            e.rgb = model[8'h30]; e.hs = 1'b1; e.vs = 1'b1; e.x = 11'd3; e.y = 10'd1; e.tag = "R3";
            sb.push_back(e);
            model[8'h30] = 24'hFEDCBA;
        end
        px(24'h000030, 2'b00, "R3");

        // R4: direct mode, both encodings
        px(24'h89ABCD, 2'b01, "R4");
        px(24'hFFFFFF, 2'b01, "R4");
        px(24'h010203, 2'b11, "R4");
        px(24'h000000, 2'b11, "R4");

        // R5: eight-colour mode, all codes with junk above bit 2
        for (int i = 0; i < 8; i++) px({21'h1ABCDE, 3'(i)}, 2'b10, "R5");

        // R6: blank in each mode
        drive(24'h000020, 2'b00, 1'b1, 1'b1, 1'b1, 11'd9, 10'd9, 1'b0, 8'd0, 24'd0, "R6");
        drive(24'hFFFFFF, 2'b01, 1'b1, 1'b1, 1'b1, 11'd9, 10'd9, 1'b0, 8'd0, 24'd0, "R6");
        drive(24'h000007, 2'b10, 1'b1, 1'b1, 1'b1, 11'd9, 10'd9, 1'b0, 8'd0, 24'd0, "R6");

        // R7/R8: sync and position patterns
        drive(24'h111111, 2'b01, 1'b1, 1'b0, 1'b1, 11'd1100, 10'd3, 1'b0, 8'd0, 24'd0, "R7");
        drive(24'h111111, 2'b01, 1'b1, 1'b0, 1'b0, 11'd1101, 10'd4, 1'b0, 8'd0, 24'd0, "R7");
        drive(24'h111111, 2'b01, 1'b1, 1'b1, 1'b0, 11'd2047, 10'd1023, 1'b0, 8'd0, 24'd0, "R8");
        drive(24'h111111, 2'b01, 1'b0, 1'b1, 1'b1, 11'd0, 10'd0, 1'b0, 8'd0, 24'd0, "R8");

        // R9: alternate mode every pixel
        for (int i = 0; i < 12; i++) px(24'hC0FF05 + 24'(i), 2'(i % 3 == 0 ? 0 : (i % 3 == 1 ? 1 : 2)), "R9");

        // drain
        drive(24'h0, 2'b01, 1'b1, 1'b1, 1'b1, 11'd0, 10'd0, 1'b0, 8'd0, 24'd0, "R6");
        repeat (4) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule